// File: doc/BRIEF.md
# Dual-Lane Bonded Receive Combiner

This block sits on the receive side of a link made of two 32-bit serial lanes that are bonded into one logical 64-bit channel. The bytes of a packet are striped across both lanes. Each lane can deliver its words rotated by a whole number of bytes after deserialisation, and the two lanes need not present matching words on the same cycle. The block repairs both problems. It then hands the link layer a stream of 64-bit words that hold one aligned 32-bit word from each lane.

Each lane has its own realignment stage. That stage finds the byte position of the comma character, keeps that position, and rebuilds every aligned word from the tail of the previous received word and the head of the current one. Any aligned word that still holds a control character is discarded, because it is an idle, sync or clock-correction filler and not payload. Aligned payload words go into a small per-lane FIFO. A combined word leaves only in a cycle in which both FIFOs hold an entry, so a lane that runs dry stalls the output and never causes an old word to be sent again. If one FIFO sits full while the other stays empty for longer than the FIFO depth, a sticky skew-error flag is raised.

Top module: `bond_rx_combiner`

## Requirements
- R1: After reset, `bond_valid` and `skew_err` are 0 and both lane FIFOs are empty.
- R2: A lane word with a control flag set on a byte equal to 8'hBC is a comma. The lowest such byte index k (0 to 3) becomes that lane's alignment offset, and it applies from that same word onward.
- R3: The offset of a lane holds its value across words that contain no comma.
- R4: Aligned byte j of a lane (j = 0 to 3, byte j in bits [8j+7:8j]) is byte k+j of the sequence made of the previous valid lane word (bytes 0 to 3) followed by the current one (bytes 4 to 7). Its control flag is taken the same way.
- R5: An aligned word with any control flag set is dropped and never reaches the output.
- R6: The first valid word on a lane after reset produces no aligned word. It only primes the lane.
- R7: A combined word is emitted only when both lane FIFOs hold an entry. It appears on `bond_data` with `bond_valid` high on the clock edge after the one at which the later of the two entries was written. No word is ever repeated.
- R8: Lane 0's word lands in `bond_data[31:0]` and lane 1's word lands in `bond_data[63:32]`. Entries pair up in arrival order per lane, whatever the skew between the lanes.
- R9: An aligned word that arrives at a full lane FIFO, in a cycle with no output, is discarded. The FIFO contents are left unchanged.
- R10: If one FIFO is full and the other empty for DEPTH+1 consecutive cycles, `skew_err` rises and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lane0_vld | input | 1 | Lane 0 word present |
| lane0_data | input | 32 | Lane 0 received word, possibly byte-rotated |
| lane0_ctl | input | 4 | Lane 0 per-byte control-character flags |
| lane1_vld | input | 1 | Lane 1 word present |
| lane1_data | input | 32 | Lane 1 received word, possibly byte-rotated |
| lane1_ctl | input | 4 | Lane 1 per-byte control-character flags |
| bond_valid | output | 1 | Combined word valid |
| bond_data | output | 64 | Combined word: lane 1 high half, lane 0 low half |
| skew_err | output | 1 | Sticky lane-skew error |

## Verification
The assertions check on every cycle the properties that depend only on FIFO occupancy. An output word is produced only when both FIFOs held an entry. Neither FIFO exceeds its depth, and a full FIFO with no pop keeps its level. The skew flag is sticky and rises only after a full/empty imbalance. The byte-level behaviour can only be shown by the bench's scenarios, by comparing against a reference model every cycle. That covers comma-driven offset changes, rebuilding words across two received words, dropping filler words in mid-stream, and pairing entries when one lane lags the other.

// File: rtl/bond_pkg.sv
// Shared constants for the bonded receive combiner.
package bond_pkg;
    localparam int         BYTE_W     = 8;
    localparam logic [7:0] COMMA_CHAR = 8'hBC;
endpackage

// File: rtl/bond_lane_align.sv
// Per-lane byte realignment.
// Finds the lowest byte holding a comma (control flag set and value COMMA_CHAR),
// keeps that index as the lane offset, and rebuilds each aligned word from the
// previous and current received words. Words still carrying a control flag are
// dropped. Assumes NB >= 2 and one received word per valid cycle.
module bond_lane_align
    import bond_pkg::*;
#(
    parameter int NB = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [NB*8-1:0]   in_data,
    input  logic [NB-1:0]     in_ctl,
    output logic              out_vld,
    output logic [NB*8-1:0]   out_data
);
    localparam int W  = NB * BYTE_W;
    localparam int OW = $clog2(NB);

    logic [W-1:0]   prev_data_q;
    logic [NB-1:0]  prev_ctl_q;
    logic           primed_q;
    logic [OW-1:0]  offset_q;

    logic           comma_hit;
    logic [OW-1:0]  comma_pos;
    logic [OW-1:0]  off_eff;
    logic [2*W-1:0] cat_data;
    logic [2*NB-1:0] cat_ctl;
    logic [W-1:0]   al_data;
    logic [NB-1:0]  al_ctl;

    // Locate the lowest comma byte in the incoming word.
    always_comb begin
        comma_hit = 1'b0;
        comma_pos = '0;
        for (int k = NB - 1; k >= 0; k--) begin
            if (in_ctl[k] && (in_data[k*BYTE_W +: BYTE_W] == COMMA_CHAR)) begin
                comma_hit = 1'b1;
                comma_pos = OW'(k);
            end
        end
    end

    // Select the offset and extract the aligned word and its flags.
    always_comb begin
        off_eff  = comma_hit ? comma_pos : offset_q;
        cat_data = {in_data, prev_data_q};
        cat_ctl  = {in_ctl, prev_ctl_q};
        al_data  = cat_data[{off_eff, 3'b000} +: W];
        al_ctl   = cat_ctl[off_eff +: NB];
    end

    // Register history, offset and the aligned payload word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_data_q <= '0;
            prev_ctl_q  <= '0;
            primed_q    <= 1'b0;
            offset_q    <= '0;
            out_vld     <= 1'b0;
            out_data    <= '0;
        end else if (in_vld) begin
            prev_data_q <= in_data;
            prev_ctl_q  <= in_ctl;
            primed_q    <= 1'b1;
            offset_q    <= off_eff;
            out_vld     <= primed_q && (al_ctl == '0);
            out_data    <= al_data;
        end else begin
            out_vld     <= 1'b0;
        end
    end
endmodule

// File: rtl/bond_sync_fifo.sv
// Small per-lane synchronisation FIFO with an occupancy count.
// A write to a full FIFO is accepted only when a read happens in the same
// cycle; otherwise it is discarded. rd_data shows the head entry. The reader
// must not read when empty.
module bond_sync_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [W-1:0]               wr_data,
    input  logic                       rd_en,
    output logic [W-1:0]               rd_data,
    output logic                       empty,
    output logic [$clog2(DEPTH+1)-1:0] fill
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp_q;
    logic [PW-1:0] rp_q;
    logic [CW-1:0] cnt_q;
    logic          full;
    logic          wr_ok;
    logic          rd_ok;

    // Derive flags and accepted operations.
    always_comb begin
        full    = (cnt_q == CW'(DEPTH));
        empty   = (cnt_q == '0);
        wr_ok   = wr_en && (!full || rd_en);
        rd_ok   = rd_en && !empty;
        rd_data = mem[rp_q];
        fill    = cnt_q;
    end

    // Store accepted entries.
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wp_q] <= wr_data;
        end
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (wr_ok) begin
                wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            end
            if (rd_ok) begin
                rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            end
            case ({wr_ok, rd_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/bond_skew_monitor.sv
// Watches the two lane FIFO levels. When one is full and the other empty for
// DEPTH+1 consecutive cycles it raises a flag that holds until reset.
module bond_skew_monitor #(
    parameter int DEPTH = 4,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] fill0,
    input  logic [CW-1:0] fill1,
    output logic          skew_err
);
    localparam int SW = $clog2(DEPTH + 1);

    logic          imbalance;
    logic [SW-1:0] run_q;

    // Detect a full/empty imbalance between the lanes.
    always_comb begin
        imbalance = ((fill0 == CW'(DEPTH)) && (fill1 == '0)) ||
                    ((fill1 == CW'(DEPTH)) && (fill0 == '0));
    end

    // Count the imbalance run and latch the error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= '0;
            skew_err <= 1'b0;
        end else if (imbalance) begin
            if (run_q == SW'(DEPTH)) begin
                skew_err <= 1'b1;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end else begin
            run_q <= '0;
        end
    end
endmodule

// File: rtl/bond_rx_combiner.sv
// Bonded two-lane receive combiner.
// Realigns each 32-bit lane, drops filler words, buffers each lane in a
// small FIFO and emits {lane1, lane0} when both lanes hold a word.
// Assumes both lanes share clk and that a comma sets the byte offset.
module bond_rx_combiner #(
    parameter int NB    = 4,
    parameter int DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lane0_vld,
    input  logic [31:0]     lane0_data,
    input  logic [3:0]      lane0_ctl,
    input  logic            lane1_vld,
    input  logic [31:0]     lane1_data,
    input  logic [3:0]      lane1_ctl,
    output logic            bond_valid,
    output logic [63:0]     bond_data,
    output logic            skew_err
);
    localparam int LANES = 2;
    localparam int W     = NB * 8;
    localparam int CW    = $clog2(DEPTH + 1);

    logic [LANES-1:0] in_vld;
    logic [W-1:0]     in_data [LANES];
    logic [NB-1:0]    in_ctl  [LANES];
    logic [LANES-1:0] al_vld;
    logic [W-1:0]     al_data [LANES];
    logic [W-1:0]     head    [LANES];
    logic [LANES-1:0] fifo_empty;
    logic [CW-1:0]    fill_a  [LANES];
    logic [CW-1:0]    fill0;
    logic [CW-1:0]    fill1;
    logic             pop;

    // Gather lane ports into arrays.
    always_comb begin
        in_vld[0]  = lane0_vld;
        in_vld[1]  = lane1_vld;
        in_data[0] = lane0_data;
        in_data[1] = lane1_data;
        in_ctl[0]  = lane0_ctl;
        in_ctl[1]  = lane1_ctl;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        bond_lane_align #(.NB(NB)) u_align (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_vld   (in_vld[g]),
            .in_data  (in_data[g]),
            .in_ctl   (in_ctl[g]),
            .out_vld  (al_vld[g]),
            .out_data (al_data[g])
        );

        bond_sync_fifo #(.DEPTH(DEPTH), .W(W)) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (al_vld[g]),
            .wr_data (al_data[g]),
            .rd_en   (pop),
            .rd_data (head[g]),
            .empty   (fifo_empty[g]),
            .fill    (fill_a[g])
        );
    end

    // Pop only when every lane has an entry.
    always_comb begin
        pop   = (fifo_empty == '0);
        fill0 = fill_a[0];
        fill1 = fill_a[1];
    end

    // Register the combined output word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bond_valid <= 1'b0;
            bond_data  <= '0;
        end else begin
            bond_valid <= pop;
            if (pop) begin
                bond_data <= {head[1], head[0]};
            end
        end
    end

    bond_skew_monitor #(.DEPTH(DEPTH), .CW(CW)) u_skew (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill0    (fill0),
        .fill1    (fill1),
        .skew_err (skew_err)
    );
endmodule

// File: rtl/bond_rx_combiner_chk.sv
// Property checker for the bonded combiner, attached by bind.
module bond_rx_combiner_chk #(
    parameter int DEPTH = 4,
    parameter int CW    = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bond_valid,
    input logic          skew_err,
    input logic [CW-1:0] fill0,
    input logic [CW-1:0] fill1,
    input logic          pop
);
    AST_NO_STALE: assert property (@(posedge clk) disable iff (!rst_n)
        bond_valid |-> $past((fill0 != '0) && (fill1 != '0))); // R7

    AST_NO_OVERFLOW0: assert property (@(posedge clk) disable iff (!rst_n)
        fill0 <= CW'(DEPTH)); // R9

    AST_NO_OVERFLOW1: assert property (@(posedge clk) disable iff (!rst_n)
        fill1 <= CW'(DEPTH)); // R9

    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(fill0) == CW'(DEPTH)) && !$past(pop)) |-> (fill0 == CW'(DEPTH))); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        skew_err |=> skew_err); // R10

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(skew_err) |-> $past(((fill0 == CW'(DEPTH)) && (fill1 == '0)) ||
                                  ((fill1 == CW'(DEPTH)) && (fill0 == '0)))); // R10
endmodule

bind bond_rx_combiner bond_rx_combiner_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bond_valid (bond_valid),
    .skew_err   (skew_err),
    .fill0      (fill0),
    .fill1      (fill1),
    .pop        (pop)
);

// File: tb/bond_rx_combiner_bench.sv
`timescale 1ns/1ps
module bond_rx_combiner_bench;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        l0v = 1'b0, l1v = 1'b0;
    logic [31:0] l0d = '0, l1d = '0;
    logic [3:0]  l0c = '0, l1c = '0;
    logic        bond_valid;
    logic [63:0] bond_data;
    logic        skew_err;

    always #2.5 clk = ~clk;

    bond_rx_combiner #(.NB(4), .DEPTH(DEPTH)) u_bond_rx_combiner (
        .clk(clk), .rst_n(rst_n),
        .lane0_vld(l0v), .lane0_data(l0d), .lane0_ctl(l0c),
        .lane1_vld(l1v), .lane1_data(l1d), .lane1_ctl(l1c),
        .bond_valid(bond_valid), .bond_data(bond_data), .skew_err(skew_err)
    );

    int    checks = 0, fails = 0, wn = 0;
    string tag = "R1";
    bit    done = 0;

    // Behavioural reference model state.
    logic [31:0] q0[$], q1[$];
    logic [31:0] pd[2];
    logic [3:0]  pc[2];
    bit          hv[2], sv[2];
    int          off[2];
    logic [31:0] sd[2];
    bit          exp_v = 0, exp_err = 0, cond;
    logic [63:0] exp_d = '0;
    int          run = 0, s0, s1;
    logic [31:0] h0, h1;

    function automatic void lane_step(int l, bit v, logic [31:0] d, logic [3:0] c);
        logic [7:0]  seq_b [8];
        bit          seq_c [8];
        logic [31:0] a;
        bit          anyc;
        sv[l] = 0;
        if (!v) return;
        for (int k = 3; k >= 0; k--)
            if (c[k] && d[8*k +: 8] == 8'hBC) off[l] = k;
        for (int i = 0; i < 4; i++) begin
            seq_b[i] = pd[l][8*i +: 8];  seq_c[i] = pc[l][i];
            seq_b[i+4] = d[8*i +: 8];    seq_c[i+4] = c[i];
        end
        anyc = 0;
        for (int j = 0; j < 4; j++) begin
            a[8*j +: 8] = seq_b[off[l] + j];
            if (seq_c[off[l] + j]) anyc = 1;
        end
        sv[l] = hv[l] && !anyc;
        sd[l] = a;
        pd[l] = d; pc[l] = c; hv[l] = 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            q0.delete(); q1.delete();
            for (int l = 0; l < 2; l++) begin
                hv[l] = 0; sv[l] = 0; off[l] = 0; pd[l] = '0; pc[l] = '0;
            end
            exp_v = 0; exp_err = 0; run = 0;
        end else begin
            s0 = q0.size(); s1 = q1.size();
            cond = (s0 == DEPTH && s1 == 0) || (s1 == DEPTH && s0 == 0);
            if (cond) begin
                if (run == DEPTH) exp_err = 1; else run++;
            end else run = 0;
            exp_v = (s0 > 0) && (s1 > 0);
            if (exp_v) begin
                h0 = q0.pop_front(); h1 = q1.pop_front();
                exp_d = {h1, h0};
            end
            if (sv[0] && q0.size() < DEPTH) q0.push_back(sd[0]);
            if (sv[1] && q1.size() < DEPTH) q1.push_back(sd[1]);
            lane_step(0, l0v, l0d, l0c);
            lane_step(1, l1v, l1d, l1c);
        end
    end

    task automatic check(bit ok, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Advance one cycle and compare every output against the model.
    task automatic tick();
        @(negedge clk);
        check(bond_valid === exp_v, "bond_valid", 64'(bond_valid), 64'(exp_v));
        if (exp_v) check(bond_data === exp_d, "bond_data", bond_data, exp_d);
        check(skew_err === exp_err, "skew_err", 64'(skew_err), 64'(exp_err));
    endtask

    function automatic logic [31:0] nw();
        wn++;
        return 32'(wn) * 32'h0103_0507 + 32'h1122_3344;
    endfunction

    task automatic drv(bit v0, logic [31:0] d0, logic [3:0] c0,
                       bit v1, logic [31:0] d1, logic [3:0] c1);
        l0v = v0; l0d = d0; l0c = c0;
        l1v = v1; l1d = d1; l1c = c1;
        tick();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drv(0, '0, '0, 0, '0, '0);
    endtask

    task automatic both(int n);
        for (int i = 0; i < n; i++) drv(1, nw(), 4'h0, 1, nw(), 4'h0);
    endtask

    task automatic do_reset();
        rst_n = 0;
        idle(3);
        rst_n = 1;
    endtask

    initial begin
        do_reset();
        tag = "R1";
        idle(3);
        check(bond_valid === 1'b0 && skew_err === 1'b0, "reset outputs",
              {skew_err, bond_valid}, 64'h0);

        tag = "R6";    // comma word at offset 0 on both lanes primes them
        drv(1, 32'h1234_56BC, 4'b0001, 1, 32'hA5A5_5ABC, 4'b0001);
        tag = "R8";
        both(6);

        tag = "R2";    // lane 0 comma at byte 2, lane 1 comma at byte 1
        drv(1, 32'h55BC_6677, 4'b0100, 1, 32'h9988_BC11, 4'b0010);
        both(6);

        tag = "R3";
        both(6);
        tag = "R4";
        both(3);

        tag = "R5";    // filler words with a non-comma control byte
        drv(1, 32'h1C00_0000, 4'b1000, 1, nw(), 4'h0);
        both(2);
        drv(1, nw(), 4'h0, 1, 32'h0000_1C00, 4'b0010);
        both(4);
        idle(4);

        tag = "R8";    // lane 1 lags lane 0 by two cycles
        for (int i = 0; i < 7; i++)
            drv(i < 5, nw(), 4'h0, i >= 2, nw(), 4'h0);
        idle(4);

        tag = "R7";    // lane 0 alone: nothing may leave
        do_reset();
        drv(1, 32'h0000_00BC, 4'b0001, 0, '0, '0);
        for (int i = 0; i < 3; i++) drv(1, nw(), 4'h0, 0, '0, '0);
        check(bond_valid === 1'b0, "no output with lane 1 empty", 64'(bond_valid), 64'h0);

        tag = "R9";    // lane 0 overfills its FIFO
        for (int i = 0; i < 8; i++) drv(1, nw(), 4'h0, 0, '0, '0);
        tag = "R10";
        idle(4);
        check(skew_err === 1'b1, "skew flag raised", 64'(skew_err), 64'h1);

        tag = "R9";    // lane 1 arrives: only the first DEPTH lane 0 words remain
        for (int i = 0; i < 6; i++) drv(0, '0, '0, 1, nw(), 4'h0);
        idle(4);
        tag = "R10";
        check(skew_err === 1'b1, "skew flag sticky", 64'(skew_err), 64'h1);

        tag = "R1";
        do_reset();
        idle(1);
        check(bond_valid === 1'b0 && skew_err === 1'b0, "reset clears",
              {skew_err, bond_valid}, 64'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog %s actual=timeout expected=completion", tag);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule